// File: doc/BRIEF.md
# Lockstep Time-Step Sequencer

This block keeps a group of neuron compute units in lockstep. For each simulated time step it sends one tick to every unit. Units may need different numbers of system clocks to update. The block waits until each of them has signalled that its update is complete, and it gathers every spike they raise while it waits. It then sends the gathered spike vector to all units at once. The next tick follows in the next cycle.

Software, or a host-side sequencer, loads a run length and a timeout limit and pulses start. The block then counts closed steps. When the count reaches the run length it raises and holds a finished flag. A step whose gathered spike vector is not all zero is also offered on a separate report port, so a host link can forward only the active steps. If some unit fails to acknowledge within the timeout limit, the run is abandoned and an error flag is raised beside the finished flag.

Top module: `lockstep_seq`

## Requirements
- R1: After reset, tick_o, bcast_valid_o, report_valid_o, finished_o and timeout_err_o are all 0, and no tick is issued until start_i is sampled high.
- R2: Each step opens with a tick_o pulse that lasts exactly one cycle. The cycle that follows a tick never carries a second tick.
- R3: A step closes only after every neuron has acknowledged. Bit j of done_i acknowledges for neuron j, and a one-cycle pulse is enough because acknowledgements are remembered until the next tick. bcast_valid_o rises in the cycle after the last outstanding acknowledgement is sampled.
- R4: Bit j of bcast_vec_o is 1 exactly when spike_i[j] was sampled high during the waiting phase of that step. bcast_valid_o is high for one cycle per closed step, including steps with no spikes.
- R5: The tick of the next step is issued in the cycle directly after the broadcast cycle, and never before it.
- R6: A run consists of exactly run_len_i ticks. After the last broadcast, finished_o goes high and stays high with no further tick. A run length of 0 finishes with no tick at all.
- R7: report_valid_o is high in a broadcast cycle exactly when bcast_vec_o is not all zero, and it is low at all other times.
- R8: If not all neurons have acknowledged after timeout_lim_i waiting cycles, timeout_err_o and finished_o rise together and no broadcast is made for that step. A limit of 0 disables the timeout.
- R9: Sampling start_i high while finished clears the step count and the error flag, and a new run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (accepted when idle or finished) |
| run_len_i | input | STEP_W | Number of steps in the run, latched at start |
| timeout_lim_i | input | TO_W | Waiting-cycle limit per step, 0 disables; latched at start |
| done_i | input | N | Per-neuron completion acknowledgement |
| spike_i | input | N | Per-neuron spike indication |
| tick_o | output | 1 | One-cycle step-start pulse |
| bcast_vec_o | output | N | Gathered spike vector of the last closed step |
| bcast_valid_o | output | 1 | One-cycle strobe qualifying bcast_vec_o |
| report_valid_o | output | 1 | Strobe for steps with at least one spike |
| finished_o | output | 1 | Run complete or abandoned |
| timeout_err_o | output | 1 | Run abandoned on missing acknowledgement |

## Verification
The bench builds the block with four neurons, an 8-bit step counter and an 8-bit timeout counter. With four neurons, every spike mix can be written out, and each neuron can be given its own acknowledgement delay between 0 and 7 cycles. This makes it possible to check stickiness and the exact closing cycle, step by step, over an eight-step run. The small timeout width puts an abandoned step within a few cycles, and the same width lets the bench exercise a limit of 0 (disabled), a run length of 0 and a restart from the finished state.

// File: rtl/lockstep_seq.sv
module lockstep_seq #(
  parameter int N      = 4,
  parameter int STEP_W = 16,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [STEP_W-1:0] run_len_i,
  input  logic [TO_W-1:0]   timeout_lim_i,
  input  logic [N-1:0]      done_i,
  input  logic [N-1:0]      spike_i,
  output logic              tick_o,
  output logic [N-1:0]      bcast_vec_o,
  output logic              bcast_valid_o,
  output logic              report_valid_o,
  output logic              finished_o,
  output logic              timeout_err_o
);

  localparam logic [N-1:0]      ALL_ACK  = {N{1'b1}};
  localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);
  localparam logic [TO_W-1:0]   TO_ONE   = TO_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_WAIT, S_BCAST, S_FIN} st_t;

  st_t               st;
  logic [STEP_W-1:0] steps, len_q;
  logic [TO_W-1:0]   to_cnt, to_lim_q;
  logic [N-1:0]      ack, acc, bvec;
  logic              err;

  logic [N-1:0] ack_nxt, acc_nxt;
  logic         all_done, to_hit;
  logic [STEP_W-1:0] steps_nxt;

  assign ack_nxt   = ack | done_i;
  assign acc_nxt   = acc | spike_i;
  assign all_done  = (ack_nxt == ALL_ACK);
  assign to_hit    = (to_lim_q != '0) && (to_cnt == to_lim_q - TO_ONE);
  assign steps_nxt = steps + STEP_ONE;

  assign tick_o         = (st == S_PULSE);
  assign bcast_valid_o  = (st == S_BCAST);
  assign bcast_vec_o    = bvec;
  assign report_valid_o = bcast_valid_o && (bvec != '0);
  assign finished_o     = (st == S_FIN);
  assign timeout_err_o  = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      steps    <= '0;
      len_q    <= '0;
      to_cnt   <= '0;
      to_lim_q <= '0;
      ack      <= '0;
      acc      <= '0;
      bvec     <= '0;
      err      <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_FIN: begin
          if (start_i) begin
            steps    <= '0;
            err      <= 1'b0;
            len_q    <= run_len_i;
            to_lim_q <= timeout_lim_i;
            st       <= (run_len_i == '0) ? S_FIN : S_PULSE;
          end
        end
        S_PULSE: begin
          ack    <= '0;
          acc    <= '0;
          to_cnt <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          ack <= ack_nxt;
          acc <= acc_nxt;
          if (all_done) begin
            bvec <= acc_nxt;
            st   <= S_BCAST;
          end else if (to_hit) begin
            err <= 1'b1;
            st  <= S_FIN;
          end else begin
            to_cnt <= to_cnt + TO_ONE;
          end
        end
        S_BCAST: begin
          steps <= steps_nxt;
          st    <= (steps_nxt == len_q) ? S_FIN : S_PULSE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R2
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid_o |=> !bcast_valid_o); // R4
  AST_TICK_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !$past(start_i)) |-> $past(bcast_valid_o)); // R5
  AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    finished_o |-> (!tick_o && !bcast_valid_o)); // R6
  AST_REPORT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    report_valid_o |-> (bcast_valid_o && |bcast_vec_o)); // R7
  AST_ERR_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err_o) |-> finished_o); // R8
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && len_q != '0) |-> (steps < len_q)); // R6

endmodule

// File: tb/tb_lockstep_seq.sv
module tb_lockstep_seq;
  localparam int N = 4;
  localparam int SW = 8;
  localparam int TW = 8;
  localparam int NV = 8;

  // {spikes[3:0], delay n3, n2, n1, n0 (3 bits each)}
  localparam logic [15:0] VEC [NV] = '{
    {4'b0000, 3'd0, 3'd0, 3'd0, 3'd0},
    {4'b0001, 3'd3, 3'd1, 3'd0, 3'd2},
    {4'b1010, 3'd7, 3'd0, 3'd0, 3'd0},
    {4'b0000, 3'd1, 3'd5, 3'd2, 3'd6},
    {4'b1111, 3'd2, 3'd2, 3'd2, 3'd2},
    {4'b0100, 3'd0, 3'd7, 3'd3, 3'd1},
    {4'b1001, 3'd6, 3'd0, 3'd6, 3'd0},
    {4'b0110, 3'd4, 3'd3, 3'd2, 3'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [SW-1:0] run_len_i = '0;
  logic [TW-1:0] timeout_lim_i = '0;
  logic [N-1:0] done_i = '0, spike_i = '0;
  logic tick_o, bcast_valid_o, report_valid_o, finished_o, timeout_err_o;
  logic [N-1:0] bcast_vec_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lockstep_seq #(.N(N), .STEP_W(SW), .TO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_len_i(run_len_i),
    .timeout_lim_i(timeout_lim_i), .done_i(done_i), .spike_i(spike_i),
    .tick_o(tick_o), .bcast_vec_o(bcast_vec_o), .bcast_valid_o(bcast_valid_o),
    .report_valid_o(report_valid_o), .finished_o(finished_o),
    .timeout_err_o(timeout_err_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input int len, input int lim);
    @(negedge clk);
    run_len_i = SW'(len);
    timeout_lim_i = TW'(lim);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ticks;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({tick_o, bcast_valid_o, report_valid_o, finished_o, timeout_err_o} == 5'b0,
        "R1", {tick_o, bcast_valid_o, report_valid_o, finished_o, timeout_err_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tick_o && !finished_o, "R1 no tick without start", tick_o, 0);

    // table-driven run: R2 R3 R4 R5 R6 R7
    launch(NV, 0);
    chk(tick_o, "R2 first tick", tick_o, 1);
    for (int i = 0; i < NV; i++) begin
      logic [3:0] spk;
      int dl [N];
      int mx;
      bit seen;
      spk = VEC[i][15:12];
      mx = 0;
      for (int j = 0; j < N; j++) begin
        dl[j] = int'(VEC[i][3*j +: 3]);
        if (dl[j] > mx) mx = dl[j];
      end
      seen = 0;
      for (int c = 0; c < 12 && !seen; c++) begin
        @(negedge clk);
        if (c == 0) chk(!tick_o, "R2 single-cycle tick", tick_o, 0);
        if (bcast_valid_o) begin
          seen = 1;
          done_i = '0;
          spike_i = '0;
          chk(c == mx + 1, "R3 close cycle", c, mx + 1);
          chk(bcast_vec_o == spk, "R4 vector", bcast_vec_o, spk);
          chk(report_valid_o == (spk != 0), "R7 report", report_valid_o, spk != 0);
        end else begin
          chk(!report_valid_o, "R7 quiet", report_valid_o, 0);
          for (int j = 0; j < N; j++) begin
            done_i[j] = (c == dl[j]);
            spike_i[j] = (c == dl[j]) && spk[j];
          end
        end
      end
      chk(seen, "R4 broadcast seen", seen, 1);
      @(negedge clk);
      if (i < NV - 1) chk(tick_o && !finished_o, "R5 next tick", tick_o, 1);
      else chk(finished_o && !tick_o, "R6 finished", finished_o, 1);
    end
    repeat (4) @(negedge clk);
    chk(finished_o && !tick_o && !timeout_err_o, "R6 finished held", finished_o, 1);

    // R6 zero-length run
    launch(0, 0);
    ticks = 0;
    for (int c = 0; c < 6; c++) begin
      if (tick_o) ticks++;
      @(negedge clk);
    end
    chk(ticks == 0 && finished_o, "R6 zero length", ticks, 0);

    // R8 timeout: neuron 3 never acknowledges, limit 3
    launch(2, 3);
    chk(tick_o, "R8 tick", tick_o, 1);
    done_i = 4'b0111;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!bcast_valid_o, "R8 no broadcast", bcast_valid_o, 0);
      if (c == 2) chk(!finished_o && !timeout_err_o, "R8 not yet", finished_o, 0);
      if (c == 3) chk(finished_o && timeout_err_o, "R8 abandoned", timeout_err_o, 1);
    end
    done_i = '0;

    // R9 restart clears error and counter; limit 0 disables timeout
    launch(2, 0);
    chk(tick_o && !timeout_err_o, "R9 restart", timeout_err_o, 0);
    ticks = 1;
    for (int c = 0; c < 60 && !finished_o; c++) begin
      @(negedge clk);
      if (tick_o) ticks++;
      done_i = (c % 25 == 20) ? 4'b1111 : 4'b0000;
    end
    done_i = '0;
    chk(finished_o && !timeout_err_o, "R8 limit zero disables", timeout_err_o, 0);
    chk(ticks == 2, "R9 fresh count", ticks, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule